// File: doc/BRIEF.md
# Grouped-Interrupt General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port. It has one direction bit per pin, an output value register, and write-only set and clear registers for atomic bit updates. Each input pin passes through a two-flop synchroniser and an optional per-pin polarity inversion before edge detection. A rising edge on an input pin is latched into a cause register. Pins are grouped eight at a time, and each group drives one interrupt request line toward a downstream interrupt aggregator.

A single mode bit chooses how group requests are retired. In edge mode, software rewrites the cause register. A group request drops when that write changes the group's cause bits and leaves all of them at zero. In level mode, cause writes have no effect. A group request drops by itself once an input in the group falls and no pin in the group is still high. A simple single-cycle register port gives access to all state. Reads are combinational from the address.

Top module: `gpio_port`

## Requirements
- R1: A write to the value register (address 2) changes only the output bits, which are the pins whose direction bit (address 0) is 1. Reading address 2 returns the driven value on output pins and the conditioned input level on input pins.
- R2: A write to the set register (address 3) ORs the data into the output bits. A write to the clear register (address 4) clears the selected output bits. Input bits are untouched by both, and both addresses read as zero.
- R3: A rising edge of the conditioned level on an input pin sets that pin's cause bit (address 5). Output pins never set cause bits.
- R4: When a pin's cause bit is set by a rising edge and its mask bit is 1, the request line irq[pin/8] rises. With the mask bit at 0, the line is not raised.
- R5: Bit 10 of the control register (address 8) selects the mode: 0 for edge, 1 for level. Reading address 8 returns 0x11FF0000 OR (mode << 10).
- R6: In edge mode, a cause write replaces the cause register. A group request drops when the write changes that group's cause bits and leaves them all zero; otherwise it stays. In level mode, cause writes are ignored.
- R7: In level mode, a falling input in a group clears that group's request when no pin of the group is still high afterwards.
- R8: Mask addresses 6 and 7 write the same single mask register, and both read it back.
- R9: A pin whose polarity bit (address 1) is 1 is inverted before edge detection. Changing the polarity alone can therefore produce an edge.
- R10: An input change applied before clock edge k appears in cause and irq after edge k+2, and not earlier.
- R11: After reset, all registers, outputs and requests are zero, and the mode is edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| gpio_in | input | NUM_PINS | Asynchronous pin inputs |
| gpio_out | output | NUM_PINS | Driven output values |
| gpio_oe | output | NUM_PINS | Output enables (direction bits) |
| irq | output | NUM_PINS/GROUP_SIZE | Per-group interrupt requests |

## Verification
Register writes take effect at the capturing edge, so gpio_out, gpio_oe and read-back data are valid on the next falling edge. A pin change needs two synchroniser edges and one more edge to reach cause and irq, so those results are due three edges after the stimulus. An edge-mode cause write clears a request at its own edge. A behavioural model in the bench advances on every rising edge with the same input values. Its outputs are compared with the design's on every falling edge, which keeps each comparison at the cycle the result is due. Directed checks also sample irq one and two edges after a pin change to confirm it has not moved early.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int REG_W    = 32;
    localparam int SEL_W    = 4;
    localparam int MODE_BIT = 10;
    localparam logic [REG_W-1:0] CTRL_FIXED = 32'h11FF_0000;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR    = 4'd0,
        SEL_POL    = 4'd1,
        SEL_VAL    = 4'd2,
        SEL_SET    = 4'd3,
        SEL_CLR    = 4'd4,
        SEL_CAUSE  = 4'd5,
        SEL_MASK_A = 4'd6,
        SEL_MASK_B = 4'd7,
        SEL_CTRL   = 4'd8
    } reg_sel_e;

    typedef enum logic {
        MODE_EDGE  = 1'b0,
        MODE_LEVEL = 1'b1
    } irq_mode_e;

    function automatic logic [REG_W-1:0] ctrl_word(input irq_mode_e m);
        return CTRL_FIXED | (REG_W'(m) << MODE_BIT);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] out_val,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall,
    output logic [W-1:0] pin_val
);
    logic [W-1:0] cond;
    logic [W-1:0] cond_q;

    assign cond = sync_in ^ pol;

    always_ff @(posedge clk) begin
        if (rst) cond_q <= '0;
        else     cond_q <= cond;
    end

    assign rise    = ~dir &  cond & ~cond_q;
    assign fall    = ~dir & ~cond &  cond_q;
    assign pin_val = (dir & out_val) | (~dir & cond);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int W   = 32,
    parameter int GRP = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W-1:0]       rise,
    input  logic [W-1:0]       fall,
    input  logic [W-1:0]       pin_val,
    input  logic [W-1:0]       mask,
    input  logic               level_mode,
    input  logic               cause_wr,
    input  logic [W-1:0]       cause_wdata,
    output logic [W-1:0]       cause,
    output logic [W/GRP-1:0]   req
);
    localparam int NG = W / GRP;

    logic edge_wr;
    assign edge_wr = cause_wr && !level_mode;

    always_ff @(posedge clk) begin
        if (rst)          cause <= '0;
        else if (edge_wr) cause <= cause_wdata | rise;
        else              cause <= cause | rise;
    end

    AST_CAUSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((cause & $past(rise)) == $past(rise)));              // R3

    AST_LEVEL_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (level_mode && cause_wr && rise == '0) |=> $stable(cause));       // R6

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic set_g, edge_clr_g, lvl_clr_g;

        assign set_g      = |(rise[g*GRP +: GRP] & mask[g*GRP +: GRP]);
        assign edge_clr_g = edge_wr
                          && (|(cause[g*GRP +: GRP] ^ cause_wdata[g*GRP +: GRP]))
                          && !(|cause_wdata[g*GRP +: GRP]);
        assign lvl_clr_g  = level_mode
                          && (|fall[g*GRP +: GRP])
                          && !(|pin_val[g*GRP +: GRP]);

        always_ff @(posedge clk) begin
            if (rst)                          req[g] <= 1'b0;
            else if (set_g)                   req[g] <= 1'b1;
            else if (edge_clr_g || lvl_clr_g) req[g] <= 1'b0;
        end

        AST_REQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $rose(req[g]) |-> (|cause[g*GRP +: GRP]));                    // R4

        AST_LEVEL_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (level_mode && (|fall[g*GRP +: GRP]) && !(|pin_val[g*GRP +: GRP])
             && !(|(rise[g*GRP +: GRP] & mask[g*GRP +: GRP])))
            |=> !req[g]);                                                 // R7
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [W-1:0]     cause,
    input  logic [W-1:0]     pin_val,
    output logic [W-1:0]     dir,
    output logic [W-1:0]     pol,
    output logic [W-1:0]     out_val,
    output logic [W-1:0]     mask,
    output logic             level_mode,
    output logic             cause_wr,
    output logic [W-1:0]     cause_wdata,
    output logic [REG_W-1:0] rdata
);
    reg_sel_e     sel;
    logic [W-1:0] wbits;
    logic [W-1:0] wout;

    assign sel         = reg_sel_e'(addr);
    assign wbits       = wdata[W-1:0];
    assign wout        = wbits & dir;
    assign cause_wr    = wr_en && (sel == SEL_CAUSE);
    assign cause_wdata = wbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir        <= '0;
            pol        <= '0;
            out_val    <= '0;
            mask       <= '0;
            level_mode <= MODE_EDGE;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR:    dir        <= wbits;
                SEL_POL:    pol        <= wbits;
                SEL_VAL:    out_val    <= (out_val & ~dir) | wout;
                SEL_SET:    out_val    <= out_val | wout;
                SEL_CLR:    out_val    <= out_val & ~wout;
                SEL_MASK_A,
                SEL_MASK_B: mask       <= wbits;
                SEL_CTRL:   level_mode <= wdata[MODE_BIT];
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_DIR:    rdata[W-1:0] = dir;
            SEL_POL:    rdata[W-1:0] = pol;
            SEL_VAL:    rdata[W-1:0] = pin_val;
            SEL_CAUSE:  rdata[W-1:0] = cause;
            SEL_MASK_A,
            SEL_MASK_B: rdata[W-1:0] = mask;
            SEL_CTRL:   rdata        = ctrl_word(irq_mode_e'(level_mode));
            default:    rdata        = '0;
        endcase
    end

    AST_SET_ONLY_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_SET)
        |=> ((out_val & $past(wbits & dir)) == $past(wbits & dir))
            && ((out_val & ~$past(dir)) == ($past(out_val) & ~$past(dir)))); // R2

    AST_MASK_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_MASK_B) |=> (mask == $past(wbits)));          // R8

    AST_CTRL_READ: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL) |-> (rdata[31:16] == 16'h11FF && rdata[9:0] == '0)); // R5
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int GROUP_SIZE = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [3:0]                     addr,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rdata,
    input  logic [NUM_PINS-1:0]            gpio_in,
    output logic [NUM_PINS-1:0]            gpio_out,
    output logic [NUM_PINS-1:0]            gpio_oe,
    output logic [NUM_PINS/GROUP_SIZE-1:0] irq
);
    localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE;

    logic [NUM_PINS-1:0] sync_in, rise, fall, pin_val;
    logic [NUM_PINS-1:0] dir, pol, out_val, mask, cause, cause_wdata;
    logic                level_mode, cause_wr;
    logic [NUM_GROUPS-1:0] req;

    gpio_sync #(.W(NUM_PINS)) i_sync (
        .clk(clk), .rst(rst), .d(gpio_in), .q(sync_in)
    );

    gpio_edge #(.W(NUM_PINS)) i_edge (
        .clk(clk), .rst(rst), .sync_in(sync_in), .pol(pol), .dir(dir),
        .out_val(out_val), .rise(rise), .fall(fall), .pin_val(pin_val)
    );

    gpio_regs #(.W(NUM_PINS)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cause(cause), .pin_val(pin_val), .dir(dir), .pol(pol),
        .out_val(out_val), .mask(mask), .level_mode(level_mode),
        .cause_wr(cause_wr), .cause_wdata(cause_wdata), .rdata(rdata)
    );

    gpio_irq_ctrl #(.W(NUM_PINS), .GRP(GROUP_SIZE)) i_irq (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .pin_val(pin_val),
        .mask(mask), .level_mode(level_mode), .cause_wr(cause_wr),
        .cause_wdata(cause_wdata), .cause(cause), .req(req)
    );

    assign gpio_out = out_val;
    assign gpio_oe  = dir;
    assign irq      = req;
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] gpio_in = '0;
    logic [31:0] gpio_out, gpio_oe;
    logic [3:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .gpio_in(gpio_in), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .irq(irq)
    );

    // behavioural reference model
    bit [31:0] m_s1, m_s2, m_pc, m_dir, m_pol, m_out, m_mask, m_cause;
    bit        m_mode;
    bit [3:0]  m_req;

    always @(posedge clk) begin
        bit [31:0] cond, rise, fall, pv, grp;
        bit        cwr, set, eclr, lclr;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_pc = 0; m_dir = 0; m_pol = 0; m_out = 0;
            m_mask = 0; m_cause = 0; m_mode = 0; m_req = 0;
        end else begin
            cond = m_s2 ^ m_pol;
            rise = ~m_dir & cond & ~m_pc;
            fall = ~m_dir & ~cond & m_pc;
            pv   = (m_dir & m_out) | (~m_dir & cond);
            cwr  = wr_en && addr == 4'd5 && !m_mode;
            for (int g = 0; g < 4; g++) begin
                grp  = 32'hFF << (8 * g);
                set  = (rise & m_mask & grp) != 0;
                eclr = cwr && ((m_cause ^ wdata) & grp) != 0 && (wdata & grp) == 0;
                lclr = m_mode && (fall & grp) != 0 && (pv & grp) == 0;
                if (set) m_req[g] = 1'b1;
                else if (eclr || lclr) m_req[g] = 1'b0;
            end
            m_cause = cwr ? (wdata | rise) : (m_cause | rise);
            if (wr_en) begin
                case (addr)
                    4'd0: m_dir = wdata;
                    4'd1: m_pol = wdata;
                    4'd2: m_out = (m_out & ~m_dir) | (wdata & m_dir);
                    4'd3: m_out = m_out | (wdata & m_dir);
                    4'd4: m_out = m_out & ~(wdata & m_dir);
                    4'd6, 4'd7: m_mask = wdata;
                    4'd8: m_mode = wdata[10];
                    default: ;
                endcase
            end
            m_pc = cond;
            m_s2 = m_s1;
            m_s1 = gpio_in;
        end
    end

    function automatic bit [31:0] model_read(input bit [3:0] a);
        case (a)
            4'd0: return m_dir;
            4'd1: return m_pol;
            4'd2: return (m_dir & m_out) | (~m_dir & (m_s2 ^ m_pol));
            4'd5: return m_cause;
            4'd6, 4'd7: return m_mask;
            4'd8: return 32'h11FF0000 | (32'(m_mode) << 10);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // compare against the model on every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(gpio_out === m_out, "R1 R2 gpio_out vs model", gpio_out, m_out);
            check(gpio_oe === m_dir, "R1 gpio_oe vs model", gpio_oe, m_dir);
            check(irq === m_req, "R4 R6 R7 irq vs model", 32'(irq), 32'(m_req));
        end
    end

    task automatic wr(input bit [3:0] a, input bit [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input bit [3:0] a, input bit [31:0] exp, input string tag);
        addr = a; #1;
        check(rdata === exp, tag, rdata, exp);
        check(rdata === model_read(a), {tag, " vs model"}, rdata, model_read(a));
    endtask

    task automatic set_in(input bit [31:0] v);
        @(negedge clk); gpio_in = v;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(irq === 4'h0, "R11 irq after reset", 32'(irq), 0);
        check(gpio_out === 0, "R11 gpio_out after reset", gpio_out, 0);
        rd(4'd0, 32'h0, "R11 dir after reset");
        rd(4'd5, 32'h0, "R11 cause after reset");
        rd(4'd8, 32'h11FF0000, "R5 R11 ctrl read edge mode");

        // R1 value write touches only outputs
        wr(4'd0, 32'h0000FFFF);
        wr(4'd2, 32'hAAAA5555);
        check(gpio_out === 32'h00005555, "R1 value write output bits only", gpio_out, 32'h5555);
        rd(4'd2, 32'h00005555, "R1 value read");

        // R2 set / clear
        wr(4'd3, 32'hFFFFFFFF);
        check(gpio_out === 32'h0000FFFF, "R2 set register", gpio_out, 32'hFFFF);
        wr(4'd4, 32'h0F0F0F0F);
        check(gpio_out === 32'h0000F0F0, "R2 clear register", gpio_out, 32'hF0F0);
        rd(4'd3, 32'h0, "R2 set reads zero");
        rd(4'd4, 32'h0, "R2 clear reads zero");

        // R8 mask alias
        wr(4'd7, 32'h00FF0000);
        rd(4'd6, 32'h00FF0000, "R8 mask alias");

        // R10 latency, R3/R4 cause and request
        set_in(32'h00010000);
        @(negedge clk); check(irq === 4'h0, "R10 irq not after one edge", 32'(irq), 0);
        @(negedge clk); check(irq === 4'h0, "R10 irq not after two edges", 32'(irq), 0);
        @(negedge clk); check(irq === 4'h4, "R4 R10 irq after three edges", 32'(irq), 4);
        rd(4'd5, 32'h00010000, "R3 cause bit set");

        set_in(32'h01010000);   // pin 24 unmasked
        cycles(4);
        check(irq === 4'h4, "R4 unmasked pin raises no request", 32'(irq), 4);
        rd(4'd5, 32'h01010000, "R3 unmasked cause bit");

        // R6 edge-mode clearing
        wr(4'd5, 32'h00010000);
        check(irq === 4'h4, "R6 unchanged group keeps request", 32'(irq), 4);
        wr(4'd5, 32'h00000000);
        check(irq === 4'h0, "R6 cleared group drops request", 32'(irq), 0);
        rd(4'd5, 32'h0, "R6 cause written");

        // R5 level mode
        wr(4'd8, 32'h00000400);
        rd(4'd8, 32'h11FF0400, "R5 ctrl read level mode");
        set_in(32'h01070000);
        cycles(3);
        check(irq === 4'h4, "R4 level mode raise", 32'(irq), 4);
        rd(4'd5, 32'h00060000, "R3 level mode cause");
        wr(4'd5, 32'h0);
        rd(4'd5, 32'h00060000, "R6 level mode cause write ignored");

        // R7 level clearing
        set_in(32'h01050000);
        cycles(3);
        check(irq === 4'h4, "R7 group still high keeps request", 32'(irq), 4);
        set_in(32'h01000000);
        cycles(3);
        check(irq === 4'h0, "R7 group all low clears request", 32'(irq), 0);

        // R9 polarity
        wr(4'd8, 32'h0);
        wr(4'd1, 32'h00100000);
        cycles(2);
        check(irq === 4'h4, "R9 polarity flip raises request", 32'(irq), 4);
        rd(4'd5, 32'h00160000, "R9 polarity cause");
        rd(4'd2, 32'h0110F0F0, "R9 R1 value read with polarity");

        // R3 output pins do not set cause
        set_in(32'h01000001);
        cycles(4);
        rd(4'd5, 32'h00160000, "R3 output pin ignored");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule